// File: doc/BRIEF.md
# HI/LO Integer Multiply-Divide Unit

A multi-cycle arithmetic unit that sits beside a 32-bit integer datapath. A start pulse, together with an opcode and two operands, launches one of four operations: a signed or unsigned multiply, or a signed or unsigned divide. The result lands in a pair of internal registers, HI and LO. The datapath reads them through two dedicated read ports and has no write path into them.

A multiply places the 64-bit product across the pair, with the upper half in HI and the lower half in LO. A divide places the remainder in HI and the quotient in LO. Both operations work on magnitudes: a shift-add multiplier or a restoring divider performs one iteration per clock. Signs are applied to the result in the same edge that writes the registers.

The unit stays busy for a fixed number of iterations, so the point at which each result appears does not depend on the operand values. A divide by zero still finishes on schedule and writes defined values.

Top module: `muldiv_hilo`

## Requirements
- R1: Opcode 1 (unsigned multiply) writes the upper 32 bits of the unsigned 64-bit product to HI and the lower 32 bits to LO; HI reads zero exactly when the product fits in LO.
- R2: Opcode 0 (signed multiply) treats both operands as two's complement and writes the signed 64-bit product across HI (upper) and LO (lower); 0x80000000 times 0x80000000 gives HI=0x40000000, LO=0x00000000.
- R3: Opcode 3 (unsigned divide) writes the quotient to LO and the remainder to HI such that dividend = quotient * divisor + remainder with remainder < divisor (78/21 gives LO=3, HI=15).
- R4: Opcode 2 (signed divide) truncates the quotient toward zero and gives the remainder the sign of the dividend; 0x80000000 / -1 gives LO=0x80000000, HI=0.
- R5: A divide with a zero divisor, signed or unsigned, writes all ones to LO and the unmodified dividend to HI, and completes with the normal timing.
- R6: A start while idle is taken at that clock edge; busy is then high for exactly 32 cycles, and done is high for exactly one cycle, the first cycle after busy falls, with the new HI/LO already visible.
- R7: HI and LO change only when an operation completes; while busy they keep returning the previous result.
- R8: A start asserted while busy is ignored: the running operation, its timing and its result are unaffected.
- R9: After reset HI and LO read zero and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation when idle |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi_rd | output | 32 | HI register: product upper half or remainder |
| lo_rd | output | 32 | LO register: product lower half or quotient |

## Verification
The edge that accepts a start is followed by 32 cycles of busy. The result and done both appear right after the 32nd iteration edge, which is the first cycle in which busy reads low. Every sample is taken on the falling clock edge. The monitor counts the busy samples and requires exactly 32 of them before each done. It compares HI/LO against the scoreboard entry only in the done cycle, and requires HI/LO to hold the previous result in every busy sample.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
   typedef enum logic [1:0] {
      MDU_MULS = 2'd0,
      MDU_MULU = 2'd1,
      MDU_DIVS = 2'd2,
      MDU_DIVU = 2'd3
   } mdu_op_e;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq #(
   parameter int STEPS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic busy,
   output logic last,
   output logic done
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

   generate
      if (STEPS < 2) begin : g_bad_steps
         $error("mdu_seq: STEPS must be at least 2");
      end
   endgenerate

   logic          busy_q, done_q;
   logic [CW-1:0] cnt_q;

   assign load = start && !busy_q;
   assign last = busy_q && (cnt_q == CW'(STEPS - 1));
   assign busy = busy_q;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_q <= last;
         if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) busy_q <= 1'b0;
         end
      end
   end

   // R6: busy holds until the final iteration
   a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !last |=> busy_q);
   // R6: done is a single-cycle pulse outside busy
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);
   // R8: the iteration count is never restarted by a start while busy
   a_r8_count_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !last |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] mcand,
   input  logic [W-1:0] mplier,
   output logic [2*W-1:0] prod_nxt
);
   logic [W-1:0] hi_q, lo_q, mc_q;
   logic [W:0]   sum, tsel;
   logic [W-1:0] hi_n, lo_n;

   always_comb begin
      sum      = {1'b0, hi_q} + {1'b0, mc_q};
      tsel     = lo_q[0] ? sum : {1'b0, hi_q};
      hi_n     = tsel[W:1];
      lo_n     = {tsel[0], lo_q[W-1:1]};
      prod_nxt = {hi_n, lo_n};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
         mc_q <= '0;
      end else if (load) begin
         hi_q <= '0;
         lo_q <= mplier;
         mc_q <= mcand;
      end else if (step) begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dvd,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] rem_nxt,
   output logic [W-1:0] quo_nxt
);
   logic [W-1:0] rem_q, quo_q, dvs_q;
   logic [W:0]   part;
   logic         ge;

   always_comb begin
      part    = {rem_q, quo_q[W-1]};
      ge      = part >= {1'b0, dvs_q};
      rem_nxt = ge ? (part[W-1:0] - dvs_q) : part[W-1:0];
      quo_nxt = {quo_q[W-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
      end else if (load) begin
         rem_q <= '0;
         quo_q <= dvd;
         dvs_q <= dvs;
      end else if (step) begin
         rem_q <= rem_nxt;
         quo_q <= quo_nxt;
      end
   end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
   import mdu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] src_a,
   input  logic [WIDTH-1:0] src_b,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] hi_rd,
   output logic [WIDTH-1:0] lo_rd
);
   localparam int W2 = 2 * WIDTH;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("muldiv_hilo: WIDTH must be at least 2");
      end
   endgenerate

   mdu_op_e op_e;
   logic is_div, sgn, neg_a, neg_b;
   logic [WIDTH-1:0] mag_a, mag_b;
   logic load, last;

   assign op_e   = mdu_op_e'(op);
   assign is_div = (op_e == MDU_DIVS) || (op_e == MDU_DIVU);
   assign sgn    = (op_e == MDU_MULS) || (op_e == MDU_DIVS);
   assign neg_a  = sgn && src_a[WIDTH-1];
   assign neg_b  = sgn && src_b[WIDTH-1];
   assign mag_a  = neg_a ? (~src_a + 1'b1) : src_a;
   assign mag_b  = neg_b ? (~src_b + 1'b1) : src_b;

   mdu_seq #(.STEPS(WIDTH)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .busy(busy), .last(last), .done(done)
   );

   logic [W2-1:0]    prod_nxt;
   logic [WIDTH-1:0] rem_nxt, quo_nxt;

   mdu_mul_core #(.W(WIDTH)) u_mul (
      .clk(clk), .rst_n(rst_n), .load(load), .step(busy),
      .mcand(mag_a), .mplier(mag_b), .prod_nxt(prod_nxt)
   );

   mdu_div_core #(.W(WIDTH)) u_div (
      .clk(clk), .rst_n(rst_n), .load(load), .step(busy),
      .dvd(mag_a), .dvs(mag_b), .rem_nxt(rem_nxt), .quo_nxt(quo_nxt)
   );

   logic             div_q, neg_res_q, neg_rem_q, dz_q;
   logic [WIDTH-1:0] dvd_q, hi_q, lo_q;
   logic [W2-1:0]    prod_fix;
   logic [WIDTH-1:0] quo_fix, rem_fix, hi_n, lo_n;

   always_comb begin
      prod_fix = neg_res_q ? (~prod_nxt + 1'b1) : prod_nxt;
      quo_fix  = neg_res_q ? (~quo_nxt + 1'b1) : quo_nxt;
      rem_fix  = neg_rem_q ? (~rem_nxt + 1'b1) : rem_nxt;
      if (!div_q) begin
         hi_n = prod_fix[W2-1:WIDTH];
         lo_n = prod_fix[WIDTH-1:0];
      end else if (dz_q) begin
         hi_n = dvd_q;
         lo_n = '1;
      end else begin
         hi_n = rem_fix;
         lo_n = quo_fix;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= 1'b0;
         neg_res_q <= 1'b0;
         neg_rem_q <= 1'b0;
         dz_q      <= 1'b0;
         dvd_q     <= '0;
         hi_q      <= '0;
         lo_q      <= '0;
      end else begin
         if (load) begin
            div_q     <= is_div;
            neg_res_q <= neg_a ^ neg_b;
            neg_rem_q <= neg_a;
            dz_q      <= is_div && (src_b == '0);
            dvd_q     <= src_a;
         end
         if (last) begin
            hi_q <= hi_n;
            lo_q <= lo_n;
         end
      end
   end

   assign hi_rd = hi_q;
   assign lo_rd = lo_q;

   // R7: the result pair only moves on the completing edge
   a_r7_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(hi_q) && $stable(lo_q));
   // R5: zero divisor yields all ones quotient and the raw dividend
   a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done && div_q && dz_q |-> (lo_q == '1) && (hi_q == dvd_q));
   // R8: operation attributes stay latched while busy
   a_r8_attr_latched: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !last |=> $stable(div_q) && $stable(dz_q) && $stable(dvd_q));
endmodule

// File: tb/sim_muldiv_hilo.sv
module sim_muldiv_hilo;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [31:0] src_a = '0, src_b = '0;
   logic        busy, done;
   logic [31:0] hi_rd, lo_rd;

   muldiv_hilo #(.WIDTH(32)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
      .hi_rd(hi_rd), .lo_rd(lo_rd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   logic [63:0] sbq[$];
   string       tagq[$];
   logic [31:0] last_hi = '0, last_lo = '0;
   int          bcnt = 0;
   bit          hold_bad = 1'b0;
   bit          finished = 1'b0;

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   function automatic logic [63:0] model(logic [1:0] o, logic [31:0] a, logic [31:0] b);
      longint sa, sb, q, r;
      logic [63:0] ua, ub;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ua = {32'd0, a};
      ub = {32'd0, b};
      case (o)
         2'd0: return 64'(sa * sb);
         2'd1: return ua * ub;
         2'd2: begin
            if (b == 0) return {a, 32'hFFFF_FFFF};
            q = sa / sb;
            r = sa % sb;
            return {r[31:0], q[31:0]};
         end
         default: begin
            if (b == 0) return {a, 32'hFFFF_FFFF};
            return {32'(ua % ub), 32'(ua / ub)};
         end
      endcase
   endfunction

   // monitor: falling-edge sampling
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) begin
            bcnt++;
            if (hi_rd !== last_hi || lo_rd !== last_lo) hold_bad = 1'b1;
         end
         if (done) begin
            logic [63:0] e;
            string t;
            chk(bcnt == 32, "R6 busy length", 64'(bcnt), 64'd32);
            chk(!hold_bad, "R7 hold while busy", {hi_rd, lo_rd}, {last_hi, last_lo});
            if (sbq.size() == 0) begin
               chk(1'b0, "R6 unexpected done", {hi_rd, lo_rd}, 64'd0);
            end else begin
               e = sbq.pop_front();
               t = tagq.pop_front();
               chk({hi_rd, lo_rd} === e, t, {hi_rd, lo_rd}, e);
            end
            last_hi = hi_rd;
            last_lo = lo_rd;
            bcnt = 0;
            hold_bad = 1'b0;
         end
      end
   end

   task automatic issue(logic [1:0] o, logic [31:0] a, logic [31:0] b, string tag, bit intrude);
      @(negedge clk);
      op = o; src_a = a; src_b = b; start = 1'b1;
      sbq.push_back(model(o, a, b));
      tagq.push_back(tag);
      @(negedge clk);
      start = 1'b0;
      op = 2'd3; src_a = 32'hDEAD_BEEF; src_b = 32'h0;
      if (intrude) begin
         repeat (5) @(negedge clk);
         op = 2'd2; src_a = 32'h1234_5678; src_b = 32'h7; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk({hi_rd, lo_rd} === 64'd0, "R9 reset HI/LO", {hi_rd, lo_rd}, 64'd0);
      chk({busy, done} === 2'b00, "R9 reset busy/done", {62'd0, busy, done}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 mulu max", 1'b0);
      issue(2'd1, 32'h0001_0000, 32'h0000_1000, "R1 mulu fits", 1'b0);
      chk(hi_rd == 0, "R1 HI zero when fits", {32'd0, hi_rd}, 64'd0);
      issue(2'd0, 32'hFFFF_FFFD, 32'd7, "R2 muls neg*pos", 1'b0);
      issue(2'd0, 32'h8000_0000, 32'h8000_0000, "R2 muls min*min", 1'b0);
      chk({hi_rd, lo_rd} === 64'h4000_0000_0000_0000, "R2 min*min literal",
          {hi_rd, lo_rd}, 64'h4000_0000_0000_0000);
      issue(2'd0, 32'hFFFF_FFFB, 32'hFFFF_FFFA, "R2 muls neg*neg", 1'b0);
      issue(2'd3, 32'd78, 32'd21, "R3 divu 78/21", 1'b0);
      chk({hi_rd, lo_rd} === {32'd15, 32'd3}, "R3 78/21 literal", {hi_rd, lo_rd}, {32'd15, 32'd3});
      issue(2'd3, 32'hFFFF_FFFF, 32'd1, "R3 divu by one", 1'b0);
      issue(2'd3, 32'd5, 32'd9, "R3 divu small", 1'b0);
      issue(2'd2, 32'hFFFF_FFF9, 32'd2, "R4 divs -7/2", 1'b0);
      chk({hi_rd, lo_rd} === {32'hFFFF_FFFF, 32'hFFFF_FFFD}, "R4 -7/2 literal",
          {hi_rd, lo_rd}, {32'hFFFF_FFFF, 32'hFFFF_FFFD});
      issue(2'd2, 32'd7, 32'hFFFF_FFFE, "R4 divs 7/-2", 1'b0);
      issue(2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R4 divs -7/-2", 1'b0);
      issue(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4 divs min/-1", 1'b0);
      issue(2'd2, 32'hFFFF_FFF7, 32'd0, "R5 divs by zero", 1'b0);
      issue(2'd3, 32'h0000_ABCD, 32'd0, "R5 divu by zero", 1'b0);
      issue(2'd1, 32'h1234_5678, 32'h9ABC_DEF0, "R8 start while busy", 1'b1);
      repeat (40) @(negedge clk);
      chk(sbq.size() == 0 && !busy, "R8 no extra operation",
          {31'd0, busy, 32'(sbq.size())}, 64'd0);
      report();
   end
endmodule